// File: doc/BRIEF.md
# SDRAM Command Sequencer with Refresh

This block sits between a host and a single-data-rate synchronous DRAM with four banks. It accepts one-word read and write requests through a valid/ready handshake. Each request becomes a row activate followed by a column read or write with auto-precharge. The block drives the active-low command pins, the bank select and the multiplexed row/column address. It drives the write data in the write cycle and captures read data after the CAS latency.

Every timing rule is a parameter counted in clock cycles. Per-bank timers stop a bank from being opened again before its row cycle and precharge have finished, and a global timer keeps activates apart. A refresh timer derives its interval from the clock frequency, the refresh window and the number of refreshes per window. A due refresh takes priority over new host requests. It is issued only when every bank is closed, and it blocks all commands for one row cycle.

Top module: `sdseq_ctrl`

## Requirements
- R1: The command pins {cs_n, ras_n, cas_n, we_n} only ever carry activate 0011, read 0101, write 0100, auto refresh 0001 or no-operation 0111. Every cycle without a command carries 0111.
- R2: The host address is {bank[20:19], row[18:8], column[7:0]}. An activate drives the row on sd_addr[10:0] and the bank on sd_ba. The read or write that follows drives the column on sd_addr[7:0], sd_addr[9:8]=0, sd_addr[10]=1 (auto-precharge) and the same bank.
- R3: A read or write appears exactly T_RCD (3) cycles after the activate of its bank.
- R4: Two activates to the same bank are at least BANK_BUSY cycles apart, where BANK_BUSY = max(T_RC, T_RAS+T_RP, T_RCD+T_DPL+T_RP), which is 10 with defaults.
- R5: Activates to any banks are at least T_RRD (2) cycles apart.
- R6: An auto refresh is issued only when every bank has passed BANK_BUSY cycles since its last activate. No other command follows within T_RC (10) cycles.
- R7: A refresh becomes due every REF_INTERVAL = CLK_KHZ*REF_WINDOW_US/(1000*REFS_PER_WINDOW) cycles. Consecutive refreshes are within REF_INTERVAL ± (BANK_BUSY+2) cycles even under continuous host load, and a window of REFS_PER_WINDOW intervals holds REFS_PER_WINDOW ± 1 refreshes.
- R8: req_ready is low in the refresh cycle and for the following T_RC-2 cycles.
- R9: sd_dq_oe is high in exactly the cycles that carry a write command, and sd_dq_out then holds that request's write data.
- R10: Each read returns exactly one rsp_valid pulse CAS_LAT (3) cycles after its read command, in request order, carrying the word last written to that address (or what the device holds).
- R11: After reset the pins carry no-operation, sd_dq_oe and rsp_valid are low and req_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Request accepted at this edge when valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 21 | {bank, row, column} |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid pulse |
| rsp_rdata | output | 32 | Read data |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_ba | output | 2 | Bank select |
| sd_addr | output | 11 | Row or column address, bit 10 auto-precharge |
| sd_dq_out | output | 32 | Data driven to the device |
| sd_dq_oe | output | 1 | Data output enable |
| sd_dq_in | input | 32 | Data from the device |

## Verification
A wrong bank timer or a lost activate count shows at the pins on the next activate or refresh. That command then comes too close to the previous activate, within at most BANK_BUSY cycles. A refresh counter or pending flag that goes wrong shows as a refresh gap outside the allowed band within one interval. A wrong column, row or bank latch shows as corrupted read data CAS_LAT cycles after the read that uses it. The bench therefore times every command against the last activate and refresh, and it keeps a model of the device contents.

// File: rtl/sdseq_pkg.sv
package sdseq_pkg;

   // Command code on {cs_n, ras_n, cas_n, we_n}
   typedef enum logic [3:0] {
      CMD_MRS = 4'b0000,
      CMD_REF = 4'b0001,
      CMD_PRE = 4'b0010,
      CMD_ACT = 4'b0011,
      CMD_WR  = 4'b0100,
      CMD_RD  = 4'b0101,
      CMD_BST = 4'b0110,
      CMD_NOP = 4'b0111
   } sd_cmd_e;

   typedef enum logic [0:0] {
      SQ_IDLE = 1'b0,
      SQ_RCD  = 1'b1
   } sd_state_e;

   function automatic int unsigned sd_max3(int unsigned a, int unsigned b, int unsigned c);
      int unsigned m;
      m = (a > b) ? a : b;
      return (m > c) ? m : c;
   endfunction

   // Cycles a bank stays closed to new activates after one activate
   function automatic int unsigned sd_bank_busy(int unsigned rc, int unsigned ras,
                                                int unsigned rp, int unsigned rcd,
                                                int unsigned dpl);
      return sd_max3(rc, ras + rp, rcd + dpl + rp);
   endfunction

   // Refresh spacing in cycles, rounded down so the window is never exceeded
   function automatic int unsigned sd_ref_interval(int unsigned khz, int unsigned win_us,
                                                   int unsigned refs);
      longint unsigned t;
      t = (longint'(khz) * longint'(win_us)) / (64'd1000 * longint'(refs));
      return int'(t);
   endfunction

endpackage

// File: rtl/sdseq_gap_timer.sv
module sdseq_gap_timer #(
   parameter int unsigned GAP = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic busy
);
   localparam int unsigned CW = (GAP > 1) ? $clog2(GAP) : 1;

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (start)
         cnt_q <= CW'(GAP - 1);
      else if (cnt_q != '0)
         cnt_q <= cnt_q - CW'(1);
   end

   assign busy = (cnt_q != '0);
endmodule

// File: rtl/sdseq_refresh_timer.sv
module sdseq_refresh_timer #(
   parameter int unsigned INTERVAL = 1953
) (
   input  logic clk,
   input  logic rst_n,
   input  logic ack,
   output logic pending
);
   localparam int unsigned CW = (INTERVAL > 1) ? $clog2(INTERVAL) : 1;

   logic [CW-1:0] cnt_q;
   logic          tick;
   logic          pend_q;

   assign tick = (cnt_q == '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q  <= CW'(INTERVAL - 1);
         pend_q <= 1'b0;
      end else begin
         cnt_q <= tick ? CW'(INTERVAL - 1) : cnt_q - CW'(1);
         if (tick)
            pend_q <= 1'b1;
         else if (ack)
            pend_q <= 1'b0;
      end
   end

   assign pending = pend_q;
endmodule

// File: rtl/sdseq_read_pipe.sv
module sdseq_read_pipe #(
   parameter int unsigned CL     = 3,
   parameter int unsigned DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              issue,
   input  logic [DATA_W-1:0] dq_in,
   output logic              rsp_valid,
   output logic [DATA_W-1:0] rsp_data
);
   logic [CL-1:0] tag_q;

   generate
      if (CL == 1) begin : g_cl1
         always_ff @(posedge clk) begin
            if (!rst_n) tag_q <= '0;
            else        tag_q <= issue;
         end
      end else begin : g_cln
         always_ff @(posedge clk) begin
            if (!rst_n) tag_q <= '0;
            else        tag_q <= {tag_q[CL-2:0], issue};
         end
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_data  <= '0;
      end else begin
         rsp_valid <= tag_q[CL-1];
         if (tag_q[CL-1])
            rsp_data <= dq_in;
      end
   end
endmodule

// File: rtl/sdseq_ctrl.sv
module sdseq_ctrl
   import sdseq_pkg::*;
#(
   parameter int unsigned DATA_W          = 32,
   parameter int unsigned BANK_W          = 2,
   parameter int unsigned ROW_W           = 11,
   parameter int unsigned COL_W           = 8,
   parameter int unsigned AP_BIT          = 10,
   parameter int unsigned T_RCD           = 3,
   parameter int unsigned T_RP            = 3,
   parameter int unsigned T_RAS           = 7,
   parameter int unsigned T_RC            = 10,
   parameter int unsigned T_RRD           = 2,
   parameter int unsigned T_DPL           = 2,
   parameter int unsigned CAS_LAT         = 3,
   parameter int unsigned CLK_KHZ         = 125000,
   parameter int unsigned REF_WINDOW_US   = 64000,
   parameter int unsigned REFS_PER_WINDOW = 4096
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            req_valid,
   output logic                            req_ready,
   input  logic                            req_write,
   input  logic [BANK_W+ROW_W+COL_W-1:0]   req_addr,
   input  logic [DATA_W-1:0]               req_wdata,
   output logic                            rsp_valid,
   output logic [DATA_W-1:0]               rsp_rdata,
   output logic                            sd_cs_n,
   output logic                            sd_ras_n,
   output logic                            sd_cas_n,
   output logic                            sd_we_n,
   output logic [BANK_W-1:0]               sd_ba,
   output logic [ROW_W-1:0]                sd_addr,
   output logic [DATA_W-1:0]               sd_dq_out,
   output logic                            sd_dq_oe,
   input  logic [DATA_W-1:0]               sd_dq_in
);
   localparam int unsigned ADDR_W       = BANK_W + ROW_W + COL_W;
   localparam int unsigned NBANK        = 1 << BANK_W;
   localparam int unsigned BANK_BUSY    = sd_bank_busy(T_RC, T_RAS, T_RP, T_RCD, T_DPL);
   localparam int unsigned REF_INTERVAL = sd_ref_interval(CLK_KHZ, REF_WINDOW_US, REFS_PER_WINDOW);
   localparam int unsigned RCD_W        = $clog2(T_RCD + 1);

   // Elaboration-time parameter checks
   generate
      if (T_RCD < 1) begin : g_bad_rcd
         $error("T_RCD must be at least one cycle");
      end
      if (CAS_LAT < 1 || CAS_LAT > T_RCD) begin : g_bad_cl
         $error("CAS_LAT must lie in 1..T_RCD so read data clears the bus before the next write");
      end
      if (AP_BIT >= ROW_W || COL_W > AP_BIT) begin : g_bad_ap
         $error("auto-precharge bit must sit inside the row field and above the column field");
      end
      if (REF_INTERVAL <= 2 * BANK_BUSY + T_RC) begin : g_bad_ref
         $error("refresh interval too short for the bank and refresh timings");
      end
   endgenerate

   // Request fields
   logic [BANK_W-1:0] req_bank;
   logic [ROW_W-1:0]  req_row;
   logic [COL_W-1:0]  req_col;

   assign req_bank = req_addr[ADDR_W-1 -: BANK_W];
   assign req_row  = req_addr[COL_W +: ROW_W];
   assign req_col  = req_addr[COL_W-1:0];

   // Sequencer state
   sd_state_e         state_q;
   logic [RCD_W-1:0]  rcd_cnt_q;
   logic [BANK_W-1:0] bank_q;
   logic [COL_W-1:0]  col_q;
   logic              write_q;
   logic [DATA_W-1:0] wdata_q;

   // Timers
   logic [NBANK-1:0]  bank_busy;
   logic              rrd_busy;
   logic              rfc_busy;
   logic              ref_pending;

   logic              can_ref;
   logic              accept;
   logic              issue_rw;
   logic              issue_rd;

   assign can_ref   = (state_q == SQ_IDLE) && ref_pending && (bank_busy == '0) && !rfc_busy;
   assign req_ready = (state_q == SQ_IDLE) && !ref_pending && !rfc_busy && !rrd_busy
                      && !bank_busy[req_bank];
   assign accept    = req_valid && req_ready;
   assign issue_rw  = (state_q == SQ_RCD) && (rcd_cnt_q == '0);
   assign issue_rd  = issue_rw && !write_q;

   generate
      for (genvar b = 0; b < NBANK; b++) begin : g_bank
         sdseq_gap_timer #(.GAP(BANK_BUSY)) u_bank_tmr (
            .clk   (clk),
            .rst_n (rst_n),
            .start (accept && (req_bank == BANK_W'(b))),
            .busy  (bank_busy[b])
         );
      end
   endgenerate

   sdseq_gap_timer #(.GAP(T_RRD)) u_rrd_tmr (
      .clk   (clk),
      .rst_n (rst_n),
      .start (accept),
      .busy  (rrd_busy)
   );

   sdseq_gap_timer #(.GAP(T_RC)) u_rfc_tmr (
      .clk   (clk),
      .rst_n (rst_n),
      .start (can_ref),
      .busy  (rfc_busy)
   );

   sdseq_refresh_timer #(.INTERVAL(REF_INTERVAL)) u_ref_tmr (
      .clk     (clk),
      .rst_n   (rst_n),
      .ack     (can_ref),
      .pending (ref_pending)
   );

   sdseq_read_pipe #(.CL(CAS_LAT), .DATA_W(DATA_W)) u_rd_pipe (
      .clk       (clk),
      .rst_n     (rst_n),
      .issue     (issue_rd),
      .dq_in     (sd_dq_in),
      .rsp_valid (rsp_valid),
      .rsp_data  (rsp_rdata)
   );

   // State sequencing
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q   <= SQ_IDLE;
         rcd_cnt_q <= '0;
         bank_q    <= '0;
         col_q     <= '0;
         write_q   <= 1'b0;
         wdata_q   <= '0;
      end else begin
         case (state_q)
            SQ_IDLE: begin
               if (accept) begin
                  state_q   <= SQ_RCD;
                  rcd_cnt_q <= RCD_W'(T_RCD - 1);
                  bank_q    <= req_bank;
                  col_q     <= req_col;
                  write_q   <= req_write;
                  wdata_q   <= req_wdata;
               end
            end
            SQ_RCD: begin
               if (rcd_cnt_q == '0)
                  state_q <= SQ_IDLE;
               else
                  rcd_cnt_q <= rcd_cnt_q - RCD_W'(1);
            end
            default: state_q <= SQ_IDLE;
         endcase
      end
   end

   // Next pin values
   sd_cmd_e           nxt_cmd;
   logic [BANK_W-1:0] nxt_ba;
   logic [ROW_W-1:0]  nxt_addr;
   logic [DATA_W-1:0] nxt_dq;
   logic              nxt_oe;

   always_comb begin
      nxt_cmd  = CMD_NOP;
      nxt_ba   = '0;
      nxt_addr = '0;
      nxt_dq   = '0;
      nxt_oe   = 1'b0;
      if (can_ref) begin
         nxt_cmd = CMD_REF;
      end else if (accept) begin
         nxt_cmd  = CMD_ACT;
         nxt_ba   = req_bank;
         nxt_addr = req_row;
      end else if (issue_rw) begin
         nxt_cmd                 = write_q ? CMD_WR : CMD_RD;
         nxt_ba                  = bank_q;
         nxt_addr[COL_W-1:0]     = col_q;
         nxt_addr[AP_BIT]        = 1'b1;
         if (write_q) begin
            nxt_oe = 1'b1;
            nxt_dq = wdata_q;
         end
      end
   end

   sd_cmd_e cmd_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cmd_q     <= CMD_NOP;
         sd_ba     <= '0;
         sd_addr   <= '0;
         sd_dq_out <= '0;
         sd_dq_oe  <= 1'b0;
      end else begin
         cmd_q     <= nxt_cmd;
         sd_ba     <= nxt_ba;
         sd_addr   <= nxt_addr;
         sd_dq_out <= nxt_dq;
         sd_dq_oe  <= nxt_oe;
      end
   end

   assign {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = cmd_q;
endmodule

// File: rtl/sdseq_checker.sv
module sdseq_checker
   import sdseq_pkg::*;
#(
   parameter int unsigned BANK_W          = 2,
   parameter int unsigned ROW_W           = 11,
   parameter int unsigned AP_BIT          = 10,
   parameter int unsigned T_RCD           = 3,
   parameter int unsigned T_RP            = 3,
   parameter int unsigned T_RAS           = 7,
   parameter int unsigned T_RC            = 10,
   parameter int unsigned T_RRD           = 2,
   parameter int unsigned T_DPL           = 2,
   parameter int unsigned CLK_KHZ         = 125000,
   parameter int unsigned REF_WINDOW_US   = 64000,
   parameter int unsigned REFS_PER_WINDOW = 4096
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cs_n,
   input logic              ras_n,
   input logic              cas_n,
   input logic              we_n,
   input logic [BANK_W-1:0] ba,
   input logic [ROW_W-1:0]  addr,
   input logic              dq_oe,
   input logic              req_ready
);
   localparam int unsigned NBANK     = 1 << BANK_W;
   localparam int unsigned BUSY      = sd_bank_busy(T_RC, T_RAS, T_RP, T_RCD, T_DPL);
   localparam int unsigned REF_INT   = sd_ref_interval(CLK_KHZ, REF_WINDOW_US, REFS_PER_WINDOW);
   localparam int unsigned REF_BOUND = REF_INT + BUSY + 2;
   localparam int unsigned CW        = $clog2(REF_BOUND + T_RC + 4) + 1;
   localparam logic [CW-1:0] SAT     = '1;

   logic [3:0] cmd;
   logic is_act, is_ref, is_rw, is_wr;

   assign cmd    = {cs_n, ras_n, cas_n, we_n};
   assign is_act = (cmd == CMD_ACT);
   assign is_ref = (cmd == CMD_REF);
   assign is_wr  = (cmd == CMD_WR);
   assign is_rw  = is_wr || (cmd == CMD_RD);

   logic [CW-1:0]     since_act;
   logic [CW-1:0]     since_ref;
   logic              ref_seen;
   logic [BANK_W-1:0] last_ba;
   logic [CW-1:0]     since_bank [NBANK];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         since_act <= SAT;
         since_ref <= '0;
         ref_seen  <= 1'b0;
         last_ba   <= '0;
      end else begin
         if (is_act) begin
            since_act <= CW'(1);
            last_ba   <= ba;
         end else if (since_act != SAT) begin
            since_act <= since_act + CW'(1);
         end
         if (is_ref) begin
            since_ref <= CW'(1);
            ref_seen  <= 1'b1;
         end else if (since_ref != SAT) begin
            since_ref <= since_ref + CW'(1);
         end
      end
   end

   generate
      for (genvar b = 0; b < NBANK; b++) begin : g_bk
         always_ff @(posedge clk) begin
            if (!rst_n)
               since_bank[b] <= SAT;
            else if (is_act && ba == BANK_W'(b))
               since_bank[b] <= CW'(1);
            else if (since_bank[b] != SAT)
               since_bank[b] <= since_bank[b] + CW'(1);
         end
      end
   endgenerate

   logic [CW-1:0] bank_gap;
   logic          all_idle;

   always_comb begin
      bank_gap = since_bank[ba];
      all_idle = 1'b1;
      for (int i = 0; i < NBANK; i++)
         if (since_bank[i] < CW'(BUSY)) all_idle = 1'b0;
   end

   a_r1_legal_cmd: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd == CMD_NOP) || is_act || is_ref || is_rw);

   a_r2_autoprecharge: assert property (@(posedge clk) disable iff (!rst_n)
      is_rw |-> addr[AP_BIT]);

   a_r3_rcd_exact: assert property (@(posedge clk) disable iff (!rst_n)
      is_rw |-> (since_act == CW'(T_RCD)) && (ba == last_ba));

   a_r4_same_bank_gap: assert property (@(posedge clk) disable iff (!rst_n)
      is_act |-> bank_gap >= CW'(BUSY));

   a_r5_rrd_gap: assert property (@(posedge clk) disable iff (!rst_n)
      is_act |-> since_act >= CW'(T_RRD));

   a_r6_ref_all_closed: assert property (@(posedge clk) disable iff (!rst_n)
      is_ref |-> all_idle);

   a_r6_ref_recovery: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd != CMD_NOP && ref_seen) |-> since_ref >= CW'(T_RC));

   a_r7_ref_due: assert property (@(posedge clk) disable iff (!rst_n)
      since_ref <= CW'(REF_BOUND));

   a_r8_ready_held: assert property (@(posedge clk) disable iff (!rst_n)
      (is_ref || (ref_seen && since_ref <= CW'(T_RC - 2))) |-> !req_ready);

   a_r9_oe_on_write: assert property (@(posedge clk) disable iff (!rst_n)
      dq_oe == is_wr);
endmodule

bind sdseq_ctrl sdseq_checker #(
   .BANK_W          (BANK_W),
   .ROW_W           (ROW_W),
   .AP_BIT          (AP_BIT),
   .T_RCD           (T_RCD),
   .T_RP            (T_RP),
   .T_RAS           (T_RAS),
   .T_RC            (T_RC),
   .T_RRD           (T_RRD),
   .T_DPL           (T_DPL),
   .CLK_KHZ         (CLK_KHZ),
   .REF_WINDOW_US   (REF_WINDOW_US),
   .REFS_PER_WINDOW (REFS_PER_WINDOW)
) u_sdseq_checker (
   .clk       (clk),
   .rst_n     (rst_n),
   .cs_n      (sd_cs_n),
   .ras_n     (sd_ras_n),
   .cas_n     (sd_cas_n),
   .we_n      (sd_we_n),
   .ba        (sd_ba),
   .addr      (sd_addr),
   .dq_oe     (sd_dq_oe),
   .req_ready (req_ready)
);

// File: tb/sdseq_ctrl_test.sv
module sdseq_ctrl_test;
   localparam int T_RCD = 3;
   localparam int T_RC  = 10;
   localparam int T_RRD = 2;
   localparam int CL    = 3;
   localparam int BUSY  = 10;
   localparam int REFS  = 32;
   localparam int INTV  = 250;
   localparam int WIN   = INTV * REFS;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic        req_write = 1'b0;
   logic [20:0] req_addr = '0;
   logic [31:0] req_wdata = '0;
   logic        rsp_valid;
   logic [31:0] rsp_rdata;
   logic        sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n;
   logic [1:0]  sd_ba;
   logic [10:0] sd_addr;
   logic [31:0] sd_dq_out;
   logic        sd_dq_oe;
   logic [31:0] sd_dq_in = '0;

   always #4 clk = ~clk;

   sdseq_ctrl #(
      .CLK_KHZ(125000), .REF_WINDOW_US(64), .REFS_PER_WINDOW(REFS)
   ) uut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
      .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
      .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n),
      .sd_ba(sd_ba), .sd_addr(sd_addr), .sd_dq_out(sd_dq_out), .sd_dq_oe(sd_dq_oe),
      .sd_dq_in(sd_dq_in)
   );

   int     nchecks = 0;
   int     nerr = 0;
   longint cyc = 0;
   bit     done = 1'b0;

   always @(posedge clk) cyc <= cyc + 1;

   task automatic check(bit ok, string tag, longint act, longint exp);
      nchecks++;
      if (!ok) begin
         nerr++;
         $display("FAIL %s: actual %0h expected %0h (cycle %0d)", tag, act, exp, cyc);
      end
   endtask

   function automatic logic [31:0] init_word(int k);
      return 32'h5EED0000 ^ k;
   endfunction

   // Host-side and device-side models
   logic [31:0] hmem [int];
   logic [31:0] bmem [int];
   logic [31:0] exp_q [$];
   longint      rdcyc_q [$];
   longint      fire_q [$];
   logic [31:0] fdat_q [$];

   longint      last_act [4];
   longint      last_act_any = -1000;
   longint      last_ref = -1000;
   logic [1:0]  last_ba = '0;
   logic [10:0] open_row [4];
   int          nref = 0;
   int          win_refs = 0;

   initial begin
      for (int i = 0; i < 4; i++) begin
         last_act[i] = -1000;
         open_row[i] = '0;
      end
   end

   // Bus monitor and device model
   always @(negedge clk) begin
      if (rst_n && !done) begin
         automatic logic [3:0] cmd = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
         automatic int key;

         if (cyc % WIN == 0) begin
            check(win_refs >= REFS - 1 && win_refs <= REFS + 1, "R7 refreshes per window",
                  win_refs, REFS);
            win_refs = 0;
         end

         check(cmd == 4'b0111 || cmd == 4'b0011 || cmd == 4'b0101 || cmd == 4'b0100 ||
               cmd == 4'b0001, "R1 legal command", cmd, 4'b0111);
         check(sd_dq_oe == (cmd == 4'b0100), "R9 oe only with write", sd_dq_oe, cmd == 4'b0100);
         if (cyc - last_ref <= T_RC - 2)
            check(!req_ready, "R8 ready low after refresh", req_ready, 0);
         if (cmd != 4'b0111)
            check(cyc - last_ref >= T_RC, "R6 refresh recovery", cyc - last_ref, T_RC);

         case (cmd)
            4'b0011: begin
               check(cyc - last_act_any >= T_RRD, "R5 activate spacing", cyc - last_act_any, T_RRD);
               check(cyc - last_act[sd_ba] >= BUSY, "R4 same-bank spacing",
                     cyc - last_act[sd_ba], BUSY);
               last_act[sd_ba] = cyc;
               last_act_any    = cyc;
               last_ba         = sd_ba;
               open_row[sd_ba] = sd_addr;
            end
            4'b0101, 4'b0100: begin
               check(cyc - last_act_any == T_RCD && sd_ba == last_ba, "R3 activate to column",
                     cyc - last_act_any, T_RCD);
               check(sd_addr[10] == 1'b1 && sd_addr[9:8] == 2'b00, "R2 column address form",
                     sd_addr[10:8], 3'b100);
               key = int'({sd_ba, open_row[sd_ba], sd_addr[7:0]});
               if (cmd == 4'b0100) begin
                  bmem[key] = sd_dq_out;
               end else begin
                  fire_q.push_back(cyc + CL - 1);
                  fdat_q.push_back(bmem.exists(key) ? bmem[key] : init_word(key));
                  rdcyc_q.push_back(cyc);
               end
            end
            4'b0001: begin
               for (int b = 0; b < 4; b++)
                  check(cyc - last_act[b] >= BUSY, "R6 refresh with banks closed",
                        cyc - last_act[b], BUSY);
               if (nref > 0)
                  check(cyc - last_ref <= INTV + BUSY + 2 && cyc - last_ref >= INTV - BUSY - 2,
                        "R7 refresh gap", cyc - last_ref, INTV);
               nref++;
               win_refs++;
               last_ref = cyc;
            end
            default: ;
         endcase

         if (fire_q.size() > 0 && fire_q[0] == cyc) begin
            sd_dq_in = fdat_q.pop_front();
            void'(fire_q.pop_front());
         end

         if (rsp_valid) begin
            if (exp_q.size() == 0 || rdcyc_q.size() == 0) begin
               check(1'b0, "R10 unexpected response", rsp_rdata, 0);
            end else begin
               automatic logic [31:0] e = exp_q.pop_front();
               automatic longint rc = rdcyc_q.pop_front();
               check(rsp_rdata == e, "R10 read data", rsp_rdata, e);
               check(cyc - rc == CL, "R10 read latency", cyc - rc, CL);
            end
         end
      end
   end

   // Driver: pushes expected read results into the scoreboard at acceptance
   task automatic do_req(bit wr, logic [20:0] a, logic [31:0] d);
      @(negedge clk);
      req_valid = 1'b1;
      req_write = wr;
      req_addr  = a;
      req_wdata = d;
      #1;
      while (!req_ready) begin
         @(negedge clk);
         #1;
      end
      @(posedge clk);
      if (wr) hmem[int'(a)] = d;
      else    exp_q.push_back(hmem.exists(int'(a)) ? hmem[int'(a)] : init_word(int'(a)));
      #1 req_valid = 1'b0;
   endtask

   function automatic logic [20:0] mk(int b, int r, int c);
      return {2'(b), 11'(r), 8'(c)};
   endfunction

   task automatic finish_run();
      $display("Simulation finished: %0d checks, %0d errors", nchecks, nerr);
      $finish;
   endtask

   initial begin
      logic [15:0] lfsr = 16'hACE1;
      repeat (5) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;
      @(negedge clk);
      check({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == 4'b0111, "R11 reset command",
            {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}, 4'b0111);
      check(!sd_dq_oe, "R11 reset oe", sd_dq_oe, 0);
      check(!rsp_valid, "R11 reset rsp_valid", rsp_valid, 0);
      check(req_ready, "R11 reset ready", req_ready, 1);

      // one write per bank, then read back (R2, R10)
      for (int b = 0; b < 4; b++) do_req(1'b1, mk(b, 100 + b, 10 * b), 32'h1000_0000 + b);
      for (int b = 0; b < 4; b++) do_req(1'b0, mk(b, 100 + b, 10 * b), 32'h0);
      // same bank, different rows back to back (R4)
      for (int r = 0; r < 4; r++) do_req(1'b1, mk(1, 2040 + r, 255), 32'hBEEF_0000 + r);
      for (int r = 0; r < 4; r++) do_req(1'b0, mk(1, 2040 + r, 255), 32'h0);
      // alternating banks (R5) and unwritten location
      for (int i = 0; i < 6; i++) do_req(i[0], mk(i % 2 == 0 ? 0 : 3, 7, i), 32'hCAFE_0000 + i);
      do_req(1'b0, mk(2, 2047, 0), 32'h0);

      // continuous mixed load across several refresh windows (R7, R8)
      while (cyc < 3 * WIN + 50) begin
         lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         do_req(lfsr[10], mk(lfsr[1:0], lfsr[4:2], lfsr[9:5]), {lfsr, ~lfsr});
      end
      repeat (20) @(negedge clk);
      check(exp_q.size() == 0, "R10 all reads answered", exp_q.size(), 0);
      check(nref >= 3 * REFS - 1, "R7 total refreshes", nref, 3 * REFS);
      done = 1'b1;
      finish_run();
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         check(1'b0, "watchdog expired", cyc, 0);
         finish_run();
      end
   end
endmodule